// File: doc/BRIEF.md
# SPI Serial Byte-Memory Slave

This block is the target side of a 512-byte serial memory reached over a four-wire SPI link. The host drops the active-low select, clocks in an 8-bit command, then follows with an address and data or clocks out bytes. The block covers:

- setting and clearing a write-enable latch;
- reading and loading a small status register;
- storing single bytes;
- streaming bytes out from a start address.

The array is an internal synchronous byte memory. For READ and WRITE, the ninth address bit travels in bit 3 of the command byte and the second byte supplies the low eight bits.

All link inputs are brought into the system clock domain through two-stage synchronizers. SCK edges are detected there, so the system clock must run at least eight times faster than SCK. Data is sampled on rising SCK edges and the output bit changes after falling edges, which serves both SPI mode 0 and mode 3. A pause input freezes the transfer mid-byte and releases the output.

Top module: `spi_eeprom_slave`

## Requirements
- R1: The first 8 bits after select falls, MSB first, form the command. Valid commands are 0x06, 0x04, 0x05, 0x01, and 0000_x011 / 0000_x010, where x is the address high bit. Any other byte, including 0x0E and 0xFF, changes no state and never turns the output on.
- R2: Command 0x06 sets the write-enable latch. Command 0x04 clears it. The latch reads back as status bit 1.
- R3: Command 0x05 streams the status byte out repeatedly, MSB first, for as long as select stays low. The status byte is: bit 0 busy, always 0; bit 1 write-enable latch; bits 3:2 protect field; bits 7:4 zero.
- R4: Command 0x01 followed by a byte, with the latch set and wp_n high, loads bits 3:2 of that byte into the protect field. All other status bits are unaffected.
- R5: Command 0x01 loads nothing while wp_n is low or while the latch is clear.
- R6: Command 0000_x010, then an address byte, then a data byte, stores the data at address {x, address byte} when the latch is set. Only one byte is stored per selection.
- R7: A write command issued while the latch is clear leaves the memory unchanged.
- R8: Command 0000_x011 plus an address byte streams bytes out starting at {x, address byte}. The address increments after each byte and wraps from 511 to 0.
- R9: When select rises after a completed store or status load, the latch clears. An aborted or refused write leaves the latch unchanged.
- R10: The output enable (so_oe) is low while deselected and during the command and address bytes. It goes high from the first falling SCK edge of the data phase.
- R11: Raising select at any bit discards the partial byte. The next selection begins again at a fresh command byte.
- R12: While hold_n is low, sampled with SCK low, SCK edges are ignored and so_oe is low. When hold_n returns high with SCK low, the transfer resumes at the same bit.
- R13: Transfers work with SCK idling low (mode 0) and idling high (mode 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x SCK |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low select |
| si | input | 1 | Serial data in |
| wp_n | input | 1 | Active-low status write protect |
| hold_n | input | 1 | Active-low transfer pause |
| so | output | 1 | Serial data out, valid when so_oe is high |
| so_oe | output | 1 | Output enable; low stands for high impedance |

## Verification
Stores and loads are tried against a table of addresses. The table includes both values of the ninth address bit and the two top and two bottom locations. This separates a decoder that drops the command's bit 3 from one that carries it into the address. A streaming read across the top of the array shows whether the address counter wraps or stalls.

Status traffic is driven with and without the latch, and with wp_n low. This shows the difference between a refused load, a completed load and the latch clearing after deselect. Commands that differ from a valid one only in bit 3 confirm that the mask applies only to READ and WRITE.

Partial bytes, a mid-byte pause and the same reads in mode 3 show that edge counting survives aborts, pauses and a different idle clock level.

// File: rtl/spi_eeprom_slave.sv
module spi_eeprom_slave #(
  parameter int AW = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic si,
  input  logic wp_n,
  input  logic hold_n,
  output logic so,
  output logic so_oe
);
  localparam int DEPTH = 1 << AW;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WRSR = 8'h01;

  typedef enum logic [2:0] {
    S_OPC, S_ADR_RD, S_ADR_WR, S_WDAT, S_SDAT, S_RDAT, S_STAT, S_SKIP
  } st_t;

  logic [1:0] sck_q, cs_q, si_q, wp_q, hold_q;
  logic       sck_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_q  <= 2'b00;
      cs_q   <= 2'b11;
      si_q   <= 2'b00;
      wp_q   <= 2'b00;
      hold_q <= 2'b11;
      sck_d  <= 1'b0;
    end else begin
      sck_q  <= {sck_q[0], sck};
      cs_q   <= {cs_q[0], cs_n};
      si_q   <= {si_q[0], si};
      wp_q   <= {wp_q[0], wp_n};
      hold_q <= {hold_q[0], hold_n};
      sck_d  <= sck_q[1];
    end

  wire sel    = !cs_q[1];
  wire sck_s  = sck_q[1];
  wire si_s   = si_q[1];
  wire wp_s   = wp_q[1];
  wire hold_s = hold_q[1];

  logic hold;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      hold <= 1'b0;
    else if (!sel)   hold <= 1'b0;
    else if (!sck_s) hold <= !hold_s;

  wire rise = sel && !hold &&  sck_s && !sck_d;
  wire fall = sel && !hold && !sck_s &&  sck_d;

  st_t           st;
  logic [2:0]    bitcnt, obit;
  logic [6:0]    sh;
  logic [AW-1:0] addr;
  logic          a8, wel, wr_done, out_on, so_r;
  logic [1:0]    bp;
  logic [7:0]    mem_q, out_sh;
  logic [7:0]    mem [DEPTH];

  wire [7:0]    byte_in   = {sh, si_s};
  wire          byte_done = rise && (bitcnt == 3'd7);
  wire [7:0]    status    = {4'b0000, bp, wel, 1'b0};
  wire [7:0]    src       = (st == S_STAT) ? status : mem_q;
  wire          x_ok      = (AW > 8) || !byte_in[3];
  wire          op_read   = (byte_in[7:4] == 4'h0) && (byte_in[2:0] == 3'b011) && x_ok;
  wire          op_write  = (byte_in[7:4] == 4'h0) && (byte_in[2:0] == 3'b010) && x_ok;
  wire [AW-1:0] addr_in   = AW'({a8, byte_in});
  wire          mem_we    = byte_done && (st == S_WDAT) && wel;
  wire          out_st    = (st == S_RDAT) || (st == S_STAT);

  always_ff @(posedge clk) begin
    if (mem_we) mem[addr] <= byte_in;
    mem_q <= mem[addr];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st      <= S_OPC;
      bitcnt  <= 3'd0;
      obit    <= 3'd0;
      sh      <= 7'd0;
      addr    <= '0;
      a8      <= 1'b0;
      wel     <= 1'b0;
      wr_done <= 1'b0;
      bp      <= 2'b00;
      out_on  <= 1'b0;
      so_r    <= 1'b0;
      out_sh  <= 8'd0;
    end else if (!sel) begin
      st      <= S_OPC;
      bitcnt  <= 3'd0;
      obit    <= 3'd0;
      out_on  <= 1'b0;
      wr_done <= 1'b0;
      if (wr_done) wel <= 1'b0;
    end else begin
      if (rise) begin
        sh     <= byte_in[6:0];
        bitcnt <= bitcnt + 3'd1;
      end
      if (byte_done) begin
        case (st)
          S_OPC: begin
            if (byte_in == OP_WREN) begin
              wel <= 1'b1;
              st  <= S_SKIP;
            end else if (byte_in == OP_WRDI) begin
              wel <= 1'b0;
              st  <= S_SKIP;
            end else if (byte_in == OP_RDSR) begin
              st   <= S_STAT;
              obit <= 3'd0;
            end else if (byte_in == OP_WRSR) begin
              st <= S_SDAT;
            end else if (op_read) begin
              a8 <= byte_in[3];
              st <= S_ADR_RD;
            end else if (op_write) begin
              a8 <= byte_in[3];
              st <= S_ADR_WR;
            end else begin
              st <= S_SKIP;
            end
          end
          S_ADR_RD: begin
            addr <= addr_in;
            obit <= 3'd0;
            st   <= S_RDAT;
          end
          S_ADR_WR: begin
            addr <= addr_in;
            st   <= S_WDAT;
          end
          S_WDAT: begin
            if (wel) wr_done <= 1'b1;
            st <= S_SKIP;
          end
          S_SDAT: begin
            if (wel && wp_s) begin
              bp      <= byte_in[3:2];
              wr_done <= 1'b1;
            end
            st <= S_SKIP;
          end
          default: ;
        endcase
      end
      if (fall && out_st) begin
        out_on <= 1'b1;
        obit   <= obit + 3'd1;
        if (obit == 3'd0) begin
          so_r   <= src[7];
          out_sh <= {src[6:0], 1'b0};
        end else begin
          so_r   <= out_sh[7];
          out_sh <= {out_sh[6:0], 1'b0};
        end
        if (obit == 3'd7 && st == S_RDAT) addr <= addr + 1'b1;
      end
    end

  assign so    = so_r;
  assign so_oe = out_on && sel && !hold;

  a_r10_release_on_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> !out_on);
  a_r2_wren_sets_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && st == S_OPC && byte_in == OP_WREN) |=> wel);
  a_r9_latch_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel && wr_done) |=> !wel);
  a_r5_wp_freezes_protect: assert property (@(posedge clk) disable iff (!rst_n)
    !wp_s |=> $stable(bp));
  a_r7_no_commit_without_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !wel) |=> !$rose(wr_done));
  a_r12_hold_freezes_counters: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && hold) |=> ($stable(bitcnt) && $stable(obit)));
  a_r8_address_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && st == S_RDAT && obit == 3'd7 && addr == {AW{1'b1}}) |=> (addr == '0));
endmodule

// File: tb/spi_eeprom_slave_tb_top.sv
module spi_eeprom_slave_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, wp_n = 1'b1, hold_n = 1'b1;
  wire  so, so_oe;
  int   n_chk = 0, n_bad = 0;
  bit   mode3 = 1'b0;
  bit   done = 1'b0;
  localparam int H = 8;

  always #5 clk = ~clk;

  spi_eeprom_slave #(.AW(9)) dut_i (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
    .wp_n(wp_n), .hold_n(hold_n), .so(so), .so_oe(so_oe)
  );

  localparam logic [16:0] VEC [8] = '{
    {9'h000, 8'h3C}, {9'h001, 8'hA5}, {9'h07F, 8'h01}, {9'h0FF, 8'h80},
    {9'h100, 8'h5A}, {9'h155, 8'hC3}, {9'h1FE, 8'h77}, {9'h1FF, 8'hE1}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic sel_on();
    sck = mode3;
    tick(H);
    cs_n = 1'b0;
    tick(H);
  endtask

  task automatic sel_off();
    if (!mode3) begin
      sck = 1'b0;
      tick(H);
    end
    cs_n = 1'b1;
    tick(2 * H);
  endtask

  task automatic xb(input logic [7:0] tx, output logic [7:0] rx,
                    output bit oe_all, output bit oe_any);
    oe_all = 1'b1;
    oe_any = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      sck = 1'b0;
      si  = tx[i];
      tick(H);
      rx[i]  = so;
      oe_all = oe_all & so_oe;
      oe_any = oe_any | so_oe;
      sck = 1'b1;
      tick(H);
    end
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] r; bit a, b;
    sel_on();
    xb(op, r, a, b);
    sel_off();
  endtask

  task automatic rdsr(output logic [7:0] s);
    logic [7:0] r; bit a, b;
    sel_on();
    xb(8'h05, r, a, b);
    xb(8'h00, s, a, b);
    sel_off();
  endtask

  task automatic wrsr(input logic [7:0] v);
    logic [7:0] r; bit a, b;
    sel_on();
    xb(8'h01, r, a, b);
    xb(v, r, a, b);
    sel_off();
  endtask

  task automatic wr_raw(input logic [8:0] ad, input logic [7:0] d);
    logic [7:0] r; bit a, b;
    sel_on();
    xb({4'h0, ad[8], 3'b010}, r, a, b);
    xb(ad[7:0], r, a, b);
    xb(d, r, a, b);
    sel_off();
  endtask

  task automatic wr_byte(input logic [8:0] ad, input logic [7:0] d);
    cmd1(8'h06);
    wr_raw(ad, d);
  endtask

  task automatic rd_start(input logic [8:0] ad, output bit oe_any);
    logic [7:0] r; bit a, b1, b2;
    sel_on();
    xb({4'h0, ad[8], 3'b011}, r, a, b1);
    xb(ad[7:0], r, a, b2);
    oe_any = b1 | b2;
  endtask

  task automatic rd_one(input logic [8:0] ad, output logic [7:0] d,
                        output bit hdr_oe, output bit dat_oe);
    bit any;
    rd_start(ad, hdr_oe);
    xb(8'h00, d, dat_oe, any);
    sel_off();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] s, d, r;
    bit ha, da, any;
    tick(4);
    chk("R10 reset oe", so_oe, 0);
    rst_n = 1'b1;
    tick(4);

    rdsr(s);
    chk("R3 initial status", s, 8'h00);
    cmd1(8'h06);
    sel_on();
    xb(8'h05, r, da, any);
    xb(8'h00, s, da, any);
    chk("R2 latch set", s, 8'h02);
    xb(8'h00, s, da, any);
    chk("R3 repeated status", s, 8'h02);
    sel_off();
    cmd1(8'h04);
    rdsr(s);
    chk("R2 latch cleared", s, 8'h00);

    cmd1(8'h0E);
    rdsr(s);
    chk("R1 bit3 not masked on 0x0E", s, 8'h00);
    sel_on();
    xb(8'hFF, r, da, any);
    xb(8'h00, r, da, ha);
    sel_off();
    chk("R1 invalid op no output", {31'd0, any | ha}, 0);

    for (int k = 0; k < 8; k++) wr_byte(VEC[k][16:8], VEC[k][7:0]);
    rdsr(s);
    chk("R9 latch cleared after store", s, 8'h00);
    for (int k = 0; k < 8; k++) begin
      rd_one(VEC[k][16:8], d, ha, da);
      chk("R6 readback", d, VEC[k][7:0]);
      chk("R10 oe low in header", {31'd0, ha}, 0);
      chk("R10 oe high in data", {31'd0, da}, 1);
    end

    wr_raw(9'h0FF, 8'h11);
    rd_one(9'h0FF, d, ha, da);
    chk("R7 store without latch", d, 8'h80);

    rd_start(9'h1FE, ha);
    xb(8'h00, d, da, any);
    chk("R8 seq byte0", d, 8'h77);
    xb(8'h00, d, da, any);
    chk("R8 seq byte1", d, 8'hE1);
    xb(8'h00, d, da, any);
    chk("R8 wrap to 0", d, 8'h3C);
    xb(8'h00, d, da, any);
    chk("R8 after wrap", d, 8'hA5);
    sel_off();

    cmd1(8'h06);
    wrsr(8'hFF);
    rdsr(s);
    chk("R4 protect loaded, R9 latch dropped", s, 8'h0C);
    wp_n = 1'b0;
    cmd1(8'h06);
    wrsr(8'h00);
    rdsr(s);
    chk("R5 wp blocks load", s, 8'h0E);
    wp_n = 1'b1;
    cmd1(8'h04);
    wrsr(8'h00);
    rdsr(s);
    chk("R5 no latch blocks load", s, 8'h0C);
    cmd1(8'h06);
    wrsr(8'h00);
    rdsr(s);
    chk("R4 protect cleared", s, 8'h00);

    cmd1(8'h06);
    sel_on();
    xb(8'h02, r, da, any);
    xb(8'h01, r, da, any);
    for (int i = 0; i < 4; i++) begin
      sck = 1'b0; si = 1'b1; tick(H);
      sck = 1'b1; tick(H);
    end
    sel_off();
    rd_one(9'h001, d, ha, da);
    chk("R11 aborted store", d, 8'hA5);
    rdsr(s);
    chk("R9 latch kept after abort", s, 8'h02);
    sel_on();
    for (int i = 0; i < 3; i++) begin
      sck = 1'b0; si = 1'b1; tick(H);
      sck = 1'b1; tick(H);
    end
    sel_off();
    cmd1(8'h04);
    rdsr(s);
    chk("R11 fresh command after partial", s, 8'h00);

    rd_start(9'h155, ha);
    si = 1'b0;
    for (int i = 7; i >= 4; i--) begin
      sck = 1'b0; tick(H);
      d[i] = so;
      sck = 1'b1; tick(H);
    end
    sck = 1'b0; tick(H);
    hold_n = 1'b0; tick(H);
    chk("R12 oe released in hold", so_oe, 0);
    sck = 1'b1; tick(H);
    sck = 1'b0; tick(H);
    hold_n = 1'b1; tick(H);
    chk("R12 oe back after hold", so_oe, 1);
    d[3] = so;
    sck = 1'b1; tick(H);
    for (int i = 2; i >= 0; i--) begin
      sck = 1'b0; tick(H);
      d[i] = so;
      sck = 1'b1; tick(H);
    end
    sel_off();
    chk("R12 byte intact across hold", d, 8'hC3);

    mode3 = 1'b1;
    rdsr(s);
    chk("R13 mode3 status", s, 8'h00);
    wr_byte(9'h155, 8'h96);
    rd_one(9'h155, d, ha, da);
    chk("R13 mode3 store/read", d, 8'h96);
    rd_one(9'h100, d, ha, da);
    chk("R13 mode3 read A8", d, 8'h5A);
    chk("R13 mode3 oe in data", {31'd0, da}, 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule